// File: doc/BRIEF.md
# Program and Erase Status Reporter

This block decides what a read returns while a nonvolatile array is busy with an internally timed byte program or a full chip erase. When a program starts it captures the data byte being written and starts a busy timer. An erase starts the same timer with a longer count. The timer runs on the system clock, so whoever starts an operation never has to supply timing pulses. Both counts are parameters given in clock cycles.

Each read strobe registers a result on `rd_data`. The value is ready in the cycle after the strobe and holds until the next strobe. While the timer runs, a read reports status in two forms at once. Bit 7 carries a polling value: the inverse of bit 7 of the captured byte during a program, and 0 during an erase, since the erased level is 1. Bit 6 is a toggle that changes on every read access. Once the timer expires, reads return the array word unchanged and bit 6 stops moving.

Reads may arrive at any point in the busy window. Command decoding and the array storage sit outside this block: it takes start pulses and the array word as inputs.

Top module: `pe_status_reporter`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` is 0, `rd_data` is all zeros and the toggle state is 0.
- R2: A `prog_start` pulse seen while idle makes `busy` 1 from the next cycle for exactly PROG_CYCLES cycles, and captures `prog_data`.
- R3: An `erase_start` pulse seen while idle makes `busy` 1 from the next cycle for exactly ERASE_CYCLES cycles.
- R4: A start pulse seen while `busy` is 1 has no effect: the busy length, the operation kind and the captured byte all stay unchanged. If both start pulses arrive together while idle, the erase is taken.
- R5: A read during a program returns, on bit 7, the inverse of bit 7 of the captured byte.
- R6: A read during an erase returns 0 on bit 7.
- R7: During an operation, bit 6 of successive reads alternates. The first read after a start returns 0, because each accepted start clears the toggle state.
- R8: During an operation, bits 5 to 0 of a read equal bits 5 to 0 of `array_data`.
- R9: A read while idle returns `array_data` on all bits. This includes a read made in the same cycle as an accepted start.
- R10: `rd_data` changes only in the cycle after a cycle with `rd_strobe` high, and holds its value otherwise.
- R11: A read strobe in the final busy cycle still returns status. The read after that returns true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | One-cycle pulse that starts a byte program |
| prog_data | input | DATA_W | Byte being programmed, captured on an accepted program start |
| erase_start | input | 1 | One-cycle pulse that starts a chip erase |
| rd_strobe | input | 1 | One read access per cycle it is high |
| array_data | input | DATA_W | Array word at the read address |
| rd_data | output | DATA_W | Registered read result |
| busy | output | 1 | High while a program or erase is timing |

## Verification
The hardest cases to reach depend on timing inside the busy window. These include a read on the very last busy cycle, a read in the same cycle as a start, and a second start that arrives mid-operation. The stimulus is written to hit these cases deliberately. A short program window lets fixed delays land each read strobe on a chosen busy cycle. Start pulses are issued while busy, followed by reads that reveal whether the captured byte or the operation kind changed. A behavioural model compares `busy` and every field of `rd_data` on every clock.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_t;
endpackage

// File: rtl/pe_busy_timer.sv
module pe_busy_timer
   import pe_status_pkg::*;
#(
   parameter int PROG_CYCLES  = 20,
   parameter int ERASE_CYCLES = 60
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     prog_start,
   input  logic     erase_start,
   output logic     busy,
   output op_kind_t op_kind,
   output logic     accept
);
   localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

   initial begin
      if (PROG_CYCLES < 1)  $error("PROG_CYCLES must be at least 1");
      if (ERASE_CYCLES < 1) $error("ERASE_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   assign accept = !busy && (prog_start || erase_start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         op_kind <= OP_PROG;
      end else if (accept) begin
         busy    <= 1'b1;
         op_kind <= erase_start ? OP_ERASE : OP_PROG;
         cnt     <= erase_start ? ERASE_LOAD : PROG_LOAD;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assert_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (cnt != '0) |=> busy);
   assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !prog_start && !erase_start |=> !busy);
   assert_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(op_kind));
endmodule

// File: rtl/pe_toggle_bit.sv
module pe_toggle_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic tog
);
   always_ff @(posedge clk) begin
      if (!rst_n)       tog <= 1'b0;
      else if (clear)   tog <= 1'b0;
      else if (advance) tog <= ~tog;
   end

   assert_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !clear |=> tog != $past(tog));
   assert_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !advance && !clear |=> $stable(tog));
endmodule

// File: rtl/pe_read_mux.sv
module pe_read_mux
   import pe_status_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic              busy,
   input  op_kind_t          op_kind,
   input  logic              held_msb,
   input  logic              tog,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int POLL_BIT = DATA_W - 1;
   localparam int TOG_BIT  = DATA_W - 2;

   initial begin
      if (DATA_W < 2) $error("DATA_W must be at least 2");
   end

   logic              poll_val;
   logic [DATA_W-1:0] status_word;

   assign poll_val = (op_kind == OP_PROG) ? ~held_msb : 1'b0;

   generate
      if (DATA_W > 2) begin : g_low_pass
         assign status_word = {poll_val, tog, array_data[TOG_BIT-1:0]};
      end else begin : g_no_low
         assign status_word = {poll_val, tog};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         rd_data <= '0;
      else if (rd_strobe) rd_data <= busy ? status_word : array_data;
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_data));
   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !busy |=> rd_data == $past(array_data));
   assert_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && busy && (op_kind == OP_PROG) |=> rd_data[POLL_BIT] == !$past(held_msb));
   assert_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && busy && (op_kind == OP_ERASE) |=> !rd_data[POLL_BIT]);
endmodule

// File: rtl/pe_status_reporter.sv
module pe_status_reporter
   import pe_status_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int PROG_CYCLES  = 20,
   parameter int ERASE_CYCLES = 60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_start,
   input  logic [DATA_W-1:0] prog_data,
   input  logic              erase_start,
   input  logic              rd_strobe,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   op_kind_t          op_kind;
   logic              accept;
   logic              tog;
   logic [DATA_W-1:0] held;

   pe_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) timer_i (
      .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
      .busy(busy), .op_kind(op_kind), .accept(accept)
   );

   pe_toggle_bit toggle_i (
      .clk(clk), .rst_n(rst_n), .clear(accept), .advance(rd_strobe && busy), .tog(tog)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                      held <= '0;
      else if (accept && !erase_start) held <= prog_data;
   end

   pe_read_mux #(.DATA_W(DATA_W)) mux_i (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .busy(busy), .op_kind(op_kind),
      .held_msb(held[DATA_W-1]), .tog(tog), .array_data(array_data), .rd_data(rd_data)
   );

   assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(held));
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(prog_start || erase_start));
endmodule

// File: tb/pe_status_reporter_tb.sv
module pe_status_reporter_tb_top;
   localparam int W = 8;
   localparam int P = 6;
   localparam int E = 15;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ps = 1'b0, es = 1'b0, rd = 1'b0;
   logic [W-1:0] pd = '0, arr = '0;
   logic [W-1:0] rd_data;
   logic         busy;

   int total = 0, bad = 0, cycles = 0;

   // behavioural reference state
   bit           m_busy = 0;
   int           rem = 0;
   bit           m_erase = 0;
   logic [W-1:0] m_held = '0;
   bit           m_tog = 0;
   logic [W-1:0] m_rd = '0;
   bit           m_read_busy = 0, m_read_idle = 0, m_ignored = 0, m_rst = 1;

   always #10 clk = ~clk;

   pe_status_reporter #(.DATA_W(W), .PROG_CYCLES(P), .ERASE_CYCLES(E)) dut_i (
      .clk(clk), .rst_n(rst_n), .prog_start(ps), .prog_data(pd), .erase_start(es),
      .rd_strobe(rd), .array_data(arr), .rd_data(rd_data), .busy(busy)
   );

   always @(posedge clk) begin
      cycles++;
      m_read_busy = 0;
      m_read_idle = 0;
      m_rst = !rst_n;
      if (!rst_n) begin
         m_busy = 0; rem = 0; m_erase = 0; m_held = '0; m_tog = 0; m_rd = '0; m_ignored = 0;
      end else begin
         if (rd) begin
            if (m_busy) begin
               m_rd = {(m_erase ? 1'b0 : ~m_held[W-1]), m_tog, arr[W-3:0]};
               m_tog = ~m_tog;
               m_read_busy = 1;
            end else begin
               m_rd = arr;
               m_read_idle = 1;
            end
         end
         if (m_busy) begin
            if (ps || es) m_ignored = 1;
            if (rem == 1) m_busy = 0; else rem--;
         end else if (es) begin
            m_busy = 1; rem = E; m_erase = 1; m_tog = 0; m_ignored = 0;
         end else if (ps) begin
            m_busy = 1; rem = P; m_erase = 0; m_held = pd; m_tog = 0; m_ignored = 0;
         end
      end
   end

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (cycles > 0) begin
         if (m_rst) begin
            chk("R1 busy", W'(busy), '0);
            chk("R1 rd_data", rd_data, '0);
         end else begin
            chk(m_ignored ? "R4 busy" : (m_erase ? "R3 busy" : "R2 busy"), W'(busy), W'(m_busy));
            if (m_read_busy) begin
               chk(m_erase ? "R6 bit7" : "R5 bit7", W'(rd_data[W-1]), W'(m_rd[W-1]));
               chk("R7 bit6", W'(rd_data[W-2]), W'(m_rd[W-2]));
               chk("R8 low bits", W'(rd_data[W-3:0]), W'(m_rd[W-3:0]));
            end else if (m_read_idle) begin
               chk("R9 idle read", rd_data, m_rd);
            end else begin
               chk("R10 hold", rd_data, m_rd);
            end
         end
      end
   end

   task automatic step(input bit p, input bit e, input logic [W-1:0] d, input bit r,
                       input logic [W-1:0] a);
      @(negedge clk);
      #1;
      ps = p; es = e; pd = d; rd = r; arr = a;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, '0, 0, 8'h3C);
   endtask

   initial begin : watchdog
      #(20 * 20000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) step(0, 0, '0, 0, 8'h55);
      rst_n = 1'b1;
      // R9: idle reads with varied data
      step(0, 0, '0, 1, 8'hA5);
      step(0, 0, '0, 1, 8'h00);
      step(0, 0, '0, 1, 8'hFF);
      idle(2);
      // R2, R5: program with bit 7 set, read every other cycle; R9 read in start cycle
      step(1, 0, 8'h80, 1, 8'h12);
      for (int i = 0; i < P + 2; i++) step(0, 0, '0, i[0], 8'h40 + 8'(i));
      // R5 with bit 7 clear, back-to-back reads, R11 last busy cycle and after
      step(1, 0, 8'h35, 0, '0);
      for (int i = 0; i < P + 1; i++) step(0, 0, '0, 1, 8'hC1 + 8'(i));
      idle(2);
      // R3, R6: erase with back-to-back reads; R4 starts during erase ignored
      step(0, 1, '0, 0, '0);
      step(0, 0, '0, 1, 8'h7E);
      step(1, 0, 8'h00, 1, 8'h81);
      step(0, 1, '0, 1, 8'h3F);
      for (int i = 0; i < E; i++) step(0, 0, '0, 1, 8'(i * 7));
      idle(2);
      // R4: program started, then program with different byte mid-run
      step(1, 0, 8'h00, 0, '0);
      step(1, 0, 8'hFF, 1, 8'h11);
      step(0, 0, '0, 1, 8'h22);
      idle(P);
      // R4: simultaneous starts pick erase
      step(1, 1, 8'h00, 0, '0);
      for (int i = 0; i < E + 2; i++) step(0, 0, '0, 1, 8'h9C ^ 8'(i));
      // mixed pattern
      for (int i = 0; i < 200; i++)
         step(($urandom % 23) == 0, ($urandom % 61) == 0, 8'($urandom),
              $urandom % 2, 8'($urandom));
      idle(E + 2);
      step(0, 0, '0, 1, 8'h5A);
      idle(2);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule